// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block supplies the 32-bit schedule word for each of the 80 rounds of a SHA-1 compression. A 512-bit message block is captured when `init_i` is pulsed. After that, each `next_i` pulse moves the schedule forward by one round, in step with the compression core that consumes the words.

The block keeps only 16 words. They sit in a chain of fixed register positions, and the whole chain shifts down by one position on every advance. The oldest word leaves the chain. A newly expanded word, formed from four taps of the current window and rotated left by one bit, enters at the top. The word at the bottom of the chain drives `w_o` with no added register stage, so the word for round t is on the output during the cycle in which the round counter stands at t.

A round counter inside the block stops the window after round 79. Later advance requests have no effect until the next `init_i`.

Top module: `sha1_msg_sched`

## Requirements
- R1: While reset is asserted, and after it is released, `w_o` is zero. `next_i` pulses given before the first `init_i` leave `w_o` at zero.
- R2: A clock edge with `init_i` high captures `blk_i`. Schedule word i (i = 0..15) is `blk_i[511-32*i -: 32]`, so word 0 is the most significant 32 bits. In the cycle after that edge, `w_o` shows word 0.
- R3: After k accepted advances since the last init (k = 0..15), `w_o` shows block word k.
- R4: After k accepted advances with k from 16 to 79, `w_o` shows W[k] = rotl1(W[k-3] ^ W[k-8] ^ W[k-14] ^ W[k-16]). Here rotl1 moves bit 31 into bit 0.
- R5: A cycle with `next_i` low and `init_i` low leaves `w_o` unchanged.
- R6: Once `w_o` shows W[79], further `next_i` pulses are ignored, and `w_o` keeps W[79] until the next init.
- R7: If `init_i` and `next_i` are high on the same edge, the init wins. An init given at any round restarts the schedule at word 0 of the new block.
- R8: The window advances at most once per clock edge. Each accepted advance moves `w_o` to the word for the following round, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Capture `blk_i` and restart at round 0 |
| next_i | input | 1 | Advance the schedule by one round |
| blk_i | input | 512 | Message block, word 0 in the top bits |
| w_o | output | 32 | Schedule word for the current round |

## Verification
The assertions assume the inputs are known (not X or Z) on every rising edge after reset. They also assume that `blk_i` matters only on edges where `init_i` is high. Beyond that, they accept any mix of `init_i` and `next_i`, including both high together, because the block has to handle every combination.

The stimulus drives all inputs at the falling edge, so they are settled well before each rising edge. It sweeps the cases of interest:
- `next_i` before any init;
- long and gapped runs of advances;
- surplus advances after round 79;
- simultaneous init and next;
- re-init partway through a schedule.

A behavioural model expands each block into all 80 words and compares `w_o` with it after every edge.

// File: rtl/sha1ws_pkg.sv
package sha1ws_pkg;

   localparam int unsigned WORD_W_DEF  = 32;
   localparam int unsigned DEPTH_DEF   = 16;
   localparam int unsigned ROUNDS_DEF  = 80;

   // window positions read by the expansion, counted from the oldest word
   localparam int unsigned TAP_OLD_DEF = 0;
   localparam int unsigned TAP_A_DEF   = 2;
   localparam int unsigned TAP_B_DEF   = 8;
   localparam int unsigned TAP_C_DEF   = 13;
   localparam int unsigned ROT_DEF     = 1;

   function automatic logic [WORD_W_DEF-1:0] rotl_word(
      input logic [WORD_W_DEF-1:0] x,
      input int unsigned           amt
   );
      logic [WORD_W_DEF-1:0] r;
      r = x;
      for (int unsigned i = 0; i < WORD_W_DEF; i++) begin
         if (i < amt) r = {r[WORD_W_DEF-2:0], r[WORD_W_DEF-1]};
      end
      return r;
   endfunction

endpackage

// File: rtl/sha1ws_round_ctr.sv
module sha1ws_round_ctr #(
   parameter int unsigned ROUNDS = sha1ws_pkg::ROUNDS_DEF,
   localparam int unsigned CNT_W = (ROUNDS > 2) ? $clog2(ROUNDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             next_i,
   output logic             load_o,
   output logic             adv_o,
   output logic [CNT_W-1:0] round_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

   logic [CNT_W-1:0] round_q;

   initial begin
      assert (ROUNDS >= 2) else $error("sha1ws_round_ctr: ROUNDS must be at least 2");
   end

   assign load_o  = init_i;
   assign adv_o   = next_i && !init_i && (round_q != LAST);
   assign round_o = round_q;

   // reset parks the counter at the last round so that advances wait for an init
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         round_q <= LAST;
      end else if (load_o) begin
         round_q <= '0;
      end else if (adv_o) begin
         round_q <= round_q + 1'b1;
      end
   end

   // R6
   round_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_q <= LAST);

   // R8
   round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |=> round_q == $past(round_q) + 1'b1);

   // R7
   round_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> round_q == '0);

   // R6
   round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round_q == LAST && !init_i) |=> round_q == LAST);

endmodule

// File: rtl/sha1ws_expand.sv
module sha1ws_expand #(
   parameter int unsigned WORD_W  = sha1ws_pkg::WORD_W_DEF,
   parameter int unsigned DEPTH   = sha1ws_pkg::DEPTH_DEF,
   parameter int unsigned TAP_OLD = sha1ws_pkg::TAP_OLD_DEF,
   parameter int unsigned TAP_A   = sha1ws_pkg::TAP_A_DEF,
   parameter int unsigned TAP_B   = sha1ws_pkg::TAP_B_DEF,
   parameter int unsigned TAP_C   = sha1ws_pkg::TAP_C_DEF,
   parameter int unsigned ROT     = sha1ws_pkg::ROT_DEF
) (
   input  logic [DEPTH-1:0][WORD_W-1:0] win_i,
   output logic [WORD_W-1:0]            new_o
);

   logic [WORD_W-1:0] mix;

   initial begin
      assert (TAP_OLD < DEPTH && TAP_A < DEPTH && TAP_B < DEPTH && TAP_C < DEPTH)
         else $error("sha1ws_expand: tap outside window");
      assert (ROT < WORD_W) else $error("sha1ws_expand: rotate too wide");
   end

   assign mix = win_i[TAP_C] ^ win_i[TAP_B] ^ win_i[TAP_A] ^ win_i[TAP_OLD];

   generate
      if (ROT == 0) begin : g_norot
         assign new_o = mix;
      end else begin : g_rot
         assign new_o = {mix[WORD_W-1-ROT:0], mix[WORD_W-1 -: ROT]};
      end
   endgenerate

endmodule

// File: rtl/sha1ws_window.sv
module sha1ws_window #(
   parameter int unsigned WORD_W = sha1ws_pkg::WORD_W_DEF,
   parameter int unsigned DEPTH  = sha1ws_pkg::DEPTH_DEF,
   localparam int unsigned BLK_W = WORD_W * DEPTH
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic                         adv_i,
   input  logic [BLK_W-1:0]             blk_i,
   input  logic [WORD_W-1:0]            new_i,
   output logic [DEPTH-1:0][WORD_W-1:0] win_o
);

   logic [DEPTH-1:0][WORD_W-1:0] win_q;

   initial begin
      assert (DEPTH >= 2) else $error("sha1ws_window: DEPTH must be at least 2");
   end

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         logic [WORD_W-1:0] shift_in;
         if (gi == DEPTH - 1) begin : g_top
            assign shift_in = new_i;
         end else begin : g_mid
            assign shift_in = win_q[gi+1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q[gi] <= '0;
            end else if (load_i) begin
               win_q[gi] <= blk_i[(DEPTH-1-gi)*WORD_W +: WORD_W];
            end else if (adv_i) begin
               win_q[gi] <= shift_in;
            end
         end
      end
   endgenerate

   assign win_o = win_q;

   // R8
   slot_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i) |=> win_q[0] == $past(win_q[1]));

   // R5
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> $stable(win_q));

   // R4
   slot_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i) |=> win_q[DEPTH-1] == $past(new_i));

endmodule

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched #(
   parameter int unsigned WORD_W = sha1ws_pkg::WORD_W_DEF,
   parameter int unsigned DEPTH  = sha1ws_pkg::DEPTH_DEF,
   parameter int unsigned ROUNDS = sha1ws_pkg::ROUNDS_DEF,
   localparam int unsigned BLK_W = WORD_W * DEPTH,
   localparam int unsigned CNT_W = (ROUNDS > 2) ? $clog2(ROUNDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              next_i,
   input  logic [BLK_W-1:0]  blk_i,
   output logic [WORD_W-1:0] w_o
);

   logic                         load;
   logic                         adv;
   logic [CNT_W-1:0]             round;
   logic [DEPTH-1:0][WORD_W-1:0] win;
   logic [WORD_W-1:0]            new_word;

   initial begin
      assert (ROUNDS > DEPTH) else $error("sha1_msg_sched: ROUNDS must exceed DEPTH");
      assert (DEPTH > sha1ws_pkg::TAP_C_DEF) else $error("sha1_msg_sched: window too shallow");
   end

   sha1ws_round_ctr #(
      .ROUNDS (ROUNDS)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (init_i),
      .next_i  (next_i),
      .load_o  (load),
      .adv_o   (adv),
      .round_o (round)
   );

   sha1ws_expand #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH)
   ) u_exp (
      .win_i (win),
      .new_o (new_word)
   );

   sha1ws_window #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .adv_i  (adv),
      .blk_i  (blk_i),
      .new_i  (new_word),
      .win_o  (win)
   );

   assign w_o = win[0];

   // R2
   load_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> w_o == $past(blk_i[BLK_W-1 -: WORD_W]));

   // R6
   end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round == CNT_W'(ROUNDS - 1) && !init_i) |=> $stable(w_o));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !next_i) |=> $stable(w_o));

endmodule

// File: tb/sha1_msg_sched_tb.sv
module sha1_msg_sched_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init_i = 1'b0;
   logic         next_i = 1'b0;
   logic [511:0] blk_i = '0;
   logic [31:0]  w_o;

   int n_run  = 0;
   int n_fail = 0;

   logic [31:0] ref_w [80];
   int          ref_idx;
   logic        ref_zero;

   always #10 clk = ~clk;

   sha1_msg_sched u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (init_i),
      .next_i (next_i),
      .blk_i  (blk_i),
      .w_o    (w_o)
   );

   function automatic logic [31:0] rol1(input logic [31:0] x);
      return {x[30:0], x[31]};
   endfunction

   task automatic build_ref(input logic [511:0] b);
      for (int t = 0; t < 80; t++) begin
         if (t < 16) ref_w[t] = b[511-32*t -: 32];
         else ref_w[t] = rol1(ref_w[t-3] ^ ref_w[t-8] ^ ref_w[t-14] ^ ref_w[t-16]);
      end
   endtask

   task automatic check(input string tag);
      logic [31:0] exp;
      exp = ref_zero ? 32'h0 : ref_w[ref_idx];
      n_run++;
      if (w_o !== exp) begin
         n_fail++;
         $display("FAIL %s round %0d: w_o=%08h expected=%08h", tag, ref_idx, w_o, exp);
      end
   endtask

   // drive on the falling edge, let the rising edge act, update the model, check at the next fall
   task automatic step(input logic ini, input logic nxt, input logic [511:0] b, input string tag);
      init_i = ini;
      next_i = nxt;
      blk_i  = b;
      @(posedge clk);
      if (ini) begin
         build_ref(b);
         ref_idx  = 0;
         ref_zero = 1'b0;
      end else if (nxt && !ref_zero && ref_idx < 79) begin
         ref_idx++;
      end
      @(negedge clk);
      init_i = 1'b0;
      next_i = 1'b0;
      check(tag);
   endtask

   function automatic logic [511:0] pattern(input int seed);
      logic [511:0] b;
      for (int i = 0; i < 16; i++)
         b[511-32*i -: 32] = 32'h9e3779b9 * (i + 1) + 32'h01000193 * seed;
      return b;
   endfunction

   initial begin
      #(20 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      ref_idx  = 0;
      ref_zero = 1'b1;
      @(negedge clk);
      check("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
      // advances before any init leave the output at zero
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, pattern(7), "R1");

      // full schedule with a structured block
      step(1'b1, 1'b0, pattern(1), "R2");
      for (int i = 1; i < 80; i++) step(1'b0, 1'b1, '0, (i < 16) ? "R3" : "R4");
      // surplus advances after the last round
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, '0, "R6");

      // all-ones block with gaps between advances
      step(1'b1, 1'b0, {512{1'b1}}, "R2");
      for (int i = 1; i < 80; i++) begin
         if (i % 3 == 0) step(1'b0, 1'b0, pattern(9), "R5");
         step(1'b0, 1'b1, '0, (i < 16) ? "R3" : "R4");
      end
      step(1'b0, 1'b1, '0, "R6");

      // init and next on the same edge, then re-init mid schedule
      step(1'b1, 1'b1, pattern(2), "R7");
      for (int i = 0; i < 30; i++) step(1'b0, 1'b1, '0, "R8");
      step(1'b1, 1'b1, pattern(3), "R7");
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '0, "R3");
      step(1'b1, 1'b0, {16{32'h80000001}}, "R7");
      for (int i = 1; i < 80; i++) step(1'b0, 1'b1, '0, (i < 16) ? "R3" : "R4");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R5");
      step(1'b0, 1'b1, '0, "R6");

      // reset in the middle of a schedule
      step(1'b1, 1'b0, pattern(4), "R2");
      step(1'b0, 1'b1, '0, "R3");
      rst_n = 1'b0;
      ref_zero = 1'b1;
      ref_idx  = 0;
      @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      step(1'b0, 1'b1, '0, "R1");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule